// File: doc/BRIEF.md
# Standby Exit Settling Timer

This block controls how the chip leaves a low-power standby state. Software programs a small control register with a 3-bit wait code and a bus-hold bit, then raises a standby request. The block enters standby, parks the external address and bus-control pins, and waits for a wake-up event. On wake-up it loads a settling down-counter with the state count chosen by the wait code. When the count reaches zero it pulses a clock-release strobe, so the oscillator has settled before the internal clock runs again.

While in standby the bus pins either float or keep the values they drove on the cycle standby was entered. The hold bit picks between the two. A second 8-bit clock-configuration register sits on the same register port. It is cleared by system reset and by hardware standby, and software standby leaves it untouched. The parameter `WAIT_SHIFT` divides every wait length by a power of two, with a floor of one state, so a test build can run short waits. Its default of 0 gives the full counts.

Top module: `stby_exit_ctl`

## Requirements
- R1: Synchronous reset and the hardware-standby input each clear both registers to 0x00, return the block to run mode, and leave `in_standby` and `clk_release` low.
- R2: Standby-control register (address 0): bit 7 is the hold bit and bits 6:4 are the wait code. Bits 3:0 always read 0, and writes to them are ignored.
- R3: Clock-configuration register (address 1) is 8 bits, readable and writable, driven on `clk_cfg`, and keeps its value through a software standby cycle.
- R4: A `stby_req` sampled high in run mode enters standby at that edge: `in_standby` is high from the next cycle on.
- R5: Wait codes 0 to 5 select 8192, 16384, 32768, 65536, 131072 and 262144 states (right-shifted by `WAIT_SHIFT`, minimum 1). `clk_release` rises exactly that many clock edges after the edge that sampled `wake`.
- R6: Reserved wait code 6 uses the longest defined wait, 262144 states (scaled as in R5).
- R7: Wait code 7 gives a 16-state wait (scaled as in R5, minimum 1).
- R8: `clk_release` is high for exactly one cycle, and `in_standby` falls at the following edge. A `wake` in run mode, or while the counter is running, has no effect.
- R9: With the hold bit 0 at standby entry, every `pin_oe` bit is 0 for the whole time `in_standby` is high.
- R10: With the hold bit 1 at standby entry, every `pin_oe` and `pin_hold` bit is 1, and `pin_val` equals the `bus_in` value sampled at the entry edge, until the release cycle.
- R11: Outside standby, `pin_val` follows `bus_in`, all `pin_oe` bits are 1 and all `pin_hold` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_stby | input | 1 | Hardware standby; clears registers and state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 standby control, 1 clock configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| clk_cfg | output | 8 | Clock-configuration register contents |
| stby_req | input | 1 | Software standby request |
| wake | input | 1 | Wake-up event |
| bus_in | input | ADDR_W+CTRL_W | Values the core drives on address and bus-control pins |
| clk_release | output | 1 | One-cycle strobe that releases the internal clock |
| in_standby | output | 1 | High from standby entry through the release cycle |
| pin_val | output | ADDR_W+CTRL_W | Pin output values |
| pin_oe | output | ADDR_W+CTRL_W | Per-pin output enable |
| pin_hold | output | ADDR_W+CTRL_W | Per-pin flag: pin is driving its held value |

## Verification
If the settling counter loads the wrong length or steps wrongly, the edge count from wake-up to `clk_release` comes out wrong. That shows on the first standby cycle for each wait code, and code 7 shows it within a cycle or two. A wrong hold latch or capture register shows on `pin_oe` or `pin_val` in the cycle right after entry, because the bench changes `bus_in` at once. State that stays stuck after release shows up as `in_standby` remaining high one cycle after the strobe.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int unsigned CNT_W = 19;

    localparam logic [CNT_W-1:0] BASE_STATES = CNT_W'(8192);
    localparam logic [CNT_W-1:0] LONG_STATES = CNT_W'(262144);
    localparam logic [CNT_W-1:0] SHORT_STATES = CNT_W'(16);

    localparam int unsigned HOLD_BIT = 7;
    localparam int unsigned CODE_LSB = 4;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PARKED = 2'd1,
        ST_SETTLE = 2'd2
    } stx_state_e;

    typedef struct packed {
        logic       hold;
        logic [2:0] code;
    } stby_cfg_t;

    function automatic logic [CNT_W-1:0] settle_count(input logic [2:0] code,
                                                      input int unsigned shift);
        logic [CNT_W-1:0] n;
        case (code)
            3'd6:    n = LONG_STATES;
            3'd7:    n = SHORT_STATES;
            default: n = BASE_STATES << code;
        endcase
        n = n >> shift;
        if (n == '0) n = CNT_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/stx_regs.sv
module stx_regs
    import stx_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  logic            we,
    input  logic            addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output stby_cfg_t       cfg,
    output logic [7:0]      clk_cfg
);

    stby_cfg_t  cfg_q;
    logic [7:0] ckr_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cfg_q <= '0;
            ckr_q <= '0;
        end else if (we) begin
            if (addr == 1'b0) begin
                cfg_q.hold <= wdata[HOLD_BIT];
                cfg_q.code <= wdata[CODE_LSB +: 3];
            end else begin
                ckr_q <= wdata;
            end
        end
    end

    always_comb begin
        if (addr == 1'b0) rdata = {cfg_q.hold, cfg_q.code, 4'b0000};
        else              rdata = ckr_q;
    end

    assign cfg     = cfg_q;
    assign clk_cfg = ckr_q;

    assert_ckr_write_R3: assert property (@(posedge clk) disable iff (clr)
        (we && addr) |=> (clk_cfg == $past(wdata)));

endmodule

// File: rtl/stx_timer.sv
module stx_timer
    import stx_pkg::*;
#(
    parameter int unsigned WAIT_SHIFT = 0
) (
    input  logic      clk,
    input  logic      clr,
    input  logic      stby_req,
    input  logic      wake,
    input  logic [2:0] code,
    output logic      enter,
    output logic      release_o,
    output logic      stby
);

    stx_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign enter     = (state == ST_RUN) && stby_req;
    assign release_o = (state == ST_SETTLE) && (cnt == '0);
    assign stby      = (state != ST_RUN);

    always_ff @(posedge clk) begin
        if (clr) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (stby_req) state <= ST_PARKED;
                end
                ST_PARKED: begin
                    if (wake) begin
                        cnt   <= settle_count(code, WAIT_SHIFT);
                        state <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == '0) state <= ST_RUN;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assert_release_single_R8: assert property (@(posedge clk) disable iff (clr)
        release_o |=> !release_o);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (clr)
        (state == ST_SETTLE && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_entry_by_request_R4: assert property (@(posedge clk) disable iff (clr)
        $rose(stby) |-> $past(stby_req));

endmodule

// File: rtl/stx_pins.sv
module stx_pins #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         enter,
    input  logic         stby,
    input  logic         hold_cfg,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] pin_val,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_hold
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (clr)        hold_q <= 1'b0;
        else if (enter) hold_q <= hold_cfg;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic held;
        always_ff @(posedge clk) begin
            if (clr)        held <= 1'b0;
            else if (enter) held <= bus_in[i];
        end
        assign pin_hold[i] = stby && hold_q;
        assign pin_oe[i]   = !stby || hold_q;
        assign pin_val[i]  = pin_hold[i] ? held : bus_in[i];
    end

    assert_held_stable_R10: assert property (@(posedge clk) disable iff (clr)
        (stby && $past(stby) && hold_q) |-> $stable(pin_val));

    assert_oe_back_R11: assert property (@(posedge clk) disable iff (clr)
        $fell(stby) |-> (&pin_oe));

endmodule

// File: rtl/stby_exit_ctl.sv
module stby_exit_ctl
    import stx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned CTRL_W     = 4,
    parameter int unsigned WAIT_SHIFT = 0,
    localparam int unsigned BUS_W     = ADDR_W + CTRL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_stby,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [7:0]       clk_cfg,
    input  logic             stby_req,
    input  logic             wake,
    input  logic [BUS_W-1:0] bus_in,
    output logic             clk_release,
    output logic             in_standby,
    output logic [BUS_W-1:0] pin_val,
    output logic [BUS_W-1:0] pin_oe,
    output logic [BUS_W-1:0] pin_hold
);

    logic      clr;
    stby_cfg_t cfg;
    logic      enter;

    assign clr = rst || hw_stby;

    stx_regs u_regs (
        .clk     (clk),
        .clr     (clr),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cfg     (cfg),
        .clk_cfg (clk_cfg)
    );

    stx_timer #(.WAIT_SHIFT(WAIT_SHIFT)) u_timer (
        .clk       (clk),
        .clr       (clr),
        .stby_req  (stby_req),
        .wake      (wake),
        .code      (cfg.code),
        .enter     (enter),
        .release_o (clk_release),
        .stby      (in_standby)
    );

    stx_pins #(.W(BUS_W)) u_pins (
        .clk      (clk),
        .clr      (clr),
        .enter    (enter),
        .stby     (in_standby),
        .hold_cfg (cfg.hold),
        .bus_in   (bus_in),
        .pin_val  (pin_val),
        .pin_oe   (pin_oe),
        .pin_hold (pin_hold)
    );

    assert_release_in_stby_R8: assert property (@(posedge clk) disable iff (clr)
        clk_release |-> in_standby);

endmodule

// File: tb/stby_exit_ctl_tb_top.sv
module stby_exit_ctl_tb_top;

    localparam int unsigned ADDR_W = 24;
    localparam int unsigned CTRL_W = 4;
    localparam int unsigned BUS_W  = ADDR_W + CTRL_W;
    localparam int unsigned SHIFT  = 6;

    logic             clk = 1'b0;
    logic             rst, hw_stby, reg_we, reg_addr;
    logic [7:0]       reg_wdata, reg_rdata, clk_cfg;
    logic             stby_req, wake;
    logic [BUS_W-1:0] bus_in, pin_val, pin_oe, pin_hold;
    logic             clk_release, in_standby;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    stby_exit_ctl #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .WAIT_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst(rst), .hw_stby(hw_stby), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_cfg(clk_cfg),
        .stby_req(stby_req), .wake(wake), .bus_in(bus_in), .clk_release(clk_release),
        .in_standby(in_standby), .pin_val(pin_val), .pin_oe(pin_oe), .pin_hold(pin_hold)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic int unsigned exp_wait(input int unsigned code);
        int unsigned b;
        if (code == 6)      b = 262144;
        else if (code == 7) b = 16;
        else                b = 8192 << code;
        b = b >> SHIFT;
        if (b == 0) b = 1;
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One full standby cycle with wait code, hold bit; optional extra wake mid-count.
    task automatic stby_cycle(input int unsigned code, input bit hold, input bit extra_wake);
        logic [BUS_W-1:0] cap;
        int unsigned n;
        int unsigned expn;
        bit seen;
        wr(1'b0, {hold, code[2:0], 4'b1010});
        @(negedge clk);
        cap = BUS_W'($urandom);
        bus_in = cap;
        stby_req = 1'b1;
        @(negedge clk);
        stby_req = 1'b0;
        chk(in_standby == 1'b1, "R4 entry", in_standby, 1);
        bus_in = ~cap;
        #1;
        if (hold) begin
            chk(pin_oe == '1 && pin_hold == '1, "R10 oe/hold", pin_oe, {BUS_W{1'b1}});
            chk(pin_val == cap, "R10 held value", pin_val, cap);
        end else begin
            chk(pin_oe == '0, "R9 float", pin_oe, 0);
        end
        repeat ($urandom_range(1, 5)) @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        expn = exp_wait(code);
        n = 0;
        seen = 1'b0;
        while (!seen && n < 5000) begin
            @(negedge clk);
            n++;
            if (extra_wake && n == 20) wake = 1'b1;
            else wake = 1'b0;
            if (clk_release) seen = 1'b1;
            else if (hold) begin
                if (pin_val != cap) chk(1'b0, "R10 held during settle", pin_val, cap);
            end else if (pin_oe != '0) chk(1'b0, "R9 float during settle", pin_oe, 0);
        end
        wake = 1'b0;
        if (code == 6)      chk(n == expn, "R6 reserved code wait", n, expn);
        else if (code == 7) chk(n == expn, "R7 short code wait", n, expn);
        else if (extra_wake) chk(n == expn, "R8 wake while counting ignored", n, expn);
        else                chk(n == expn, "R5 wait length", n, expn);
        chk(in_standby == 1'b1, "R8 standby during release", in_standby, 1);
        @(negedge clk);
        chk(clk_release == 1'b0 && in_standby == 1'b0, "R8 single strobe and exit",
            {clk_release, in_standby}, 0);
        chk(pin_oe == '1 && pin_hold == '0 && pin_val == bus_in, "R11 normal drive",
            pin_val, bus_in);
    endtask

    initial begin
        logic [7:0] d;
        rst = 1'b1; hw_stby = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        stby_req = 1'b0; wake = 1'b0; bus_in = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(1'b0, d); chk(d == 8'h00, "R1 reset standby reg", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R1 reset clock reg", d, 0);
        chk(in_standby == 1'b0 && clk_release == 1'b0, "R1 reset outputs",
            {in_standby, clk_release}, 0);

        wr(1'b0, 8'hFF);
        rd(1'b0, d); chk(d == 8'hF0, "R2 low bits read zero", d, 8'hF0);
        wr(1'b1, 8'hA5);
        rd(1'b1, d); chk(d == 8'hA5 && clk_cfg == 8'hA5, "R3 clock reg write", d, 8'hA5);

        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0;
        rd(1'b0, d); chk(d == 8'h00, "R1 hw standby clears standby reg", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R1 hw standby clears clock reg", d, 0);

        // wake in run mode is ignored
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        chk(in_standby == 1'b0 && clk_release == 1'b0, "R8 wake in run ignored",
            {in_standby, clk_release}, 0);

        wr(1'b1, 8'h3C);
        for (int c = 0; c < 8; c++) begin
            stby_cycle(c, 1'b0, 1'b0);
            stby_cycle(c, 1'b1, 1'b0);
        end
        rd(1'b1, d); chk(d == 8'h3C, "R3 clock reg kept through standby", d, 8'h3C);

        stby_cycle(0, 1'b1, 1'b1);
        stby_cycle(2, 1'b0, 1'b1);

        for (int k = 0; k < 10; k++) begin
            stby_cycle($urandom_range(0, 7), 1'($urandom), 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule